// File: doc/BRIEF.md
# Sector Erase Batching Window

This block gathers sector erase requests into one batch before the embedded erase is launched. The first decoded sector erase request opens a timed acceptance window. Each later request adds its sector to a selection bitmap and restarts the full window. When a whole window passes with no new request, the block closes the window and raises a status flag. It then blocks the request path and gives the collected bitmap to the erase engine with a one-cycle start pulse. The erase engine later returns a done pulse, which clears the flag and the bitmap.

The window length is a parameter in clock cycles, chosen so that it covers the nominal spacing (about 50 µs) within which host requests are always accepted. An erase suspend that arrives while the window is open cancels the batch and launches nothing. A suspend that arrives during the erase is passed on to the engine. Whole-chip erase does not go through this block.

Top module: `erase_batch_window`

## Requirements
- R1: After reset, win_closed_o is 0, sect_map_o is all zero, erase_start_o is 0 and susp_fwd_o is 0.
- R2: A sector request (sect_cmd_i high, sector index on sect_idx_i) in the idle state opens the window. From the next cycle, bit sect_idx_i of sect_map_o is 1 (bit i stands for sector i) and win_closed_o stays 0.
- R3: The window expires exactly WINDOW_CYCLES rising clock edges after the edge that sampled the last accepted request. At that edge win_closed_o becomes 1 and erase_start_o is high for exactly one cycle.
- R4: A sector request sampled k edges after the previous accepted one, with 1 <= k < WINDOW_CYCLES, is accepted. Its bit is set and the full window restarts from that edge.
- R5: A sector request sampled on the expiry edge itself is rejected and its bit is not set. win_closed_o still rises and the start pulse still fires on the original schedule.
- R6: While win_closed_o is 1, sector requests are ignored. sect_map_o does not change and no further start pulse is issued.
- R7: An erase_done_i pulse while win_closed_o is 1 clears win_closed_o and sect_map_o at the next edge and returns the block to idle.
- R8: A suspend (susp_cmd_i) sampled while the window is open cancels the batch. sect_map_o clears, win_closed_o stays 0 and no start pulse follows. Suspend wins over a sector request in the same cycle.
- R9: susp_fwd_o follows susp_cmd_i in the same cycle while win_closed_o is 1, and is 0 at all other times.
- R10: erase_done_i is ignored when no erase is running. An open window keeps its bitmap and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sect_cmd_i | input | 1 | Decoded sector erase request strobe |
| sect_idx_i | input | SECT_W | Sector index for the request |
| susp_cmd_i | input | 1 | Erase suspend strobe |
| erase_done_i | input | 1 | Erase engine completion pulse |
| win_closed_o | output | 1 | Status flag: 0 while idle or collecting, 1 once the erase has begun |
| sect_map_o | output | NUM_SECTORS | Selected sector bitmap |
| erase_start_o | output | 1 | One-cycle launch pulse for the erase engine |
| susp_fwd_o | output | 1 | Suspend forwarded to the erase engine |

## Verification
The hardest case to reach is a second request that lands exactly on the edge where the window counter runs out. Here the request has to lose, and the flag still has to rise on time. The bench reaches this case with a sweep. For every spacing from one cycle up to the full window, it places a second request that many edges after the first. It then measures the latency to the start pulse and the final bitmap. This covers both the last spacing that is accepted and the first spacing that is rejected. A suspend that coincides with a request, and a stray done pulse inside an open window, are driven in the same way on exact cycle counts.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_ERASE = 2'd2
  } ebw_state_e;

  typedef struct packed {
    logic load;
    logic run;
    logic clr;
  } ebw_ctr_cmd_t;

  typedef struct packed {
    logic set;
    logic clr;
  } ebw_map_cmd_t;

endpackage

// File: rtl/ebw_window_ctr.sv
module ebw_window_ctr #(
  parameter int WINDOW_CYCLES = 4000,
  localparam int CW = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ebw_pkg::ebw_ctr_cmd_t  cmd_i,
  output logic                   last_o
);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] next_count(
    input logic [CW-1:0] cur,
    input ebw_pkg::ebw_ctr_cmd_t c
  );
    logic [CW-1:0] r;
    r = cur;
    if (c.clr)                 r = '0;
    else if (c.load)           r = CW'(WINDOW_CYCLES);
    else if (c.run && cur != '0) r = cur - 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, cmd_i);
  end

  assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/ebw_sector_map.sv
module ebw_sector_map #(
  parameter int NUM_SECTORS = 64,
  localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ebw_pkg::ebw_map_cmd_t  cmd_i,
  input  logic [SECT_W-1:0]      idx_i,
  output logic [NUM_SECTORS-1:0] map_o
);

  logic [NUM_SECTORS-1:0] map_q;
  logic [NUM_SECTORS-1:0] sel_w;

  function automatic logic [NUM_SECTORS-1:0] decode(input logic [SECT_W-1:0] idx);
    logic [NUM_SECTORS-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_SECTORS; i++) begin
      if (idx == SECT_W'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction

  assign sel_w = decode(idx_i);

  genvar g;
  generate
    for (g = 0; g < NUM_SECTORS; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      map_q[g] <= 1'b0;
        else if (cmd_i.clr)              map_q[g] <= 1'b0;
        else if (cmd_i.set && sel_w[g])  map_q[g] <= 1'b1;
      end
    end
  endgenerate

  assign map_o = map_q;

endmodule

// File: rtl/ebw_ctrl.sv
module ebw_ctrl
  import ebw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sect_cmd_i,
  input  logic          susp_cmd_i,
  input  logic          erase_done_i,
  input  logic          last_i,
  output ebw_ctr_cmd_t  ctr_cmd_o,
  output ebw_map_cmd_t  map_cmd_o,
  output logic          closed_o,
  output logic          start_o,
  output logic          susp_fwd_o,
  output logic          open_o,
  output logic          accept_o,
  output logic          expire_o,
  output logic          abort_o
);

  ebw_state_e state_q, state_d;
  logic       start_q;

  always_comb begin
    open_o   = (state_q == ST_OPEN);
    abort_o  = open_o && susp_cmd_i;
    expire_o = open_o && !susp_cmd_i && last_i;
    accept_o = sect_cmd_i && !susp_cmd_i &&
               ((state_q == ST_IDLE) || (open_o && !last_i));
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_OPEN;
      ST_OPEN: begin
        if (abort_o)       state_d = ST_IDLE;
        else if (expire_o) state_d = ST_ERASE;
      end
      ST_ERASE: if (erase_done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ctr_cmd_o.load = accept_o;
    ctr_cmd_o.run  = open_o;
    ctr_cmd_o.clr  = abort_o || expire_o;
    map_cmd_o.set  = accept_o;
    map_cmd_o.clr  = abort_o || ((state_q == ST_ERASE) && erase_done_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= expire_o;
    end
  end

  assign closed_o   = (state_q == ST_ERASE);
  assign start_o    = start_q;
  assign susp_fwd_o = closed_o && susp_cmd_i;

endmodule

// File: rtl/erase_batch_window.sv
module erase_batch_window #(
  parameter int NUM_SECTORS   = 64,
  parameter int WINDOW_CYCLES = 4000,
  localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sect_cmd_i,
  input  logic [SECT_W-1:0]      sect_idx_i,
  input  logic                   susp_cmd_i,
  input  logic                   erase_done_i,
  output logic                   win_closed_o,
  output logic [NUM_SECTORS-1:0] sect_map_o,
  output logic                   erase_start_o,
  output logic                   susp_fwd_o
);

  ebw_pkg::ebw_ctr_cmd_t ctr_cmd_w;
  ebw_pkg::ebw_map_cmd_t map_cmd_w;
  logic last_w;
  logic win_open_w;
  logic accept_w;
  logic expire_w;
  logic abort_w;

  ebw_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sect_cmd_i   (sect_cmd_i),
    .susp_cmd_i   (susp_cmd_i),
    .erase_done_i (erase_done_i),
    .last_i       (last_w),
    .ctr_cmd_o    (ctr_cmd_w),
    .map_cmd_o    (map_cmd_w),
    .closed_o     (win_closed_o),
    .start_o      (erase_start_o),
    .susp_fwd_o   (susp_fwd_o),
    .open_o       (win_open_w),
    .accept_o     (accept_w),
    .expire_o     (expire_w),
    .abort_o      (abort_w)
  );

  ebw_window_ctr #(.WINDOW_CYCLES(WINDOW_CYCLES)) ctr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (ctr_cmd_w),
    .last_o (last_w)
  );

  ebw_sector_map #(.NUM_SECTORS(NUM_SECTORS)) map_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_i (map_cmd_w),
    .idx_i (sect_idx_i),
    .map_o (sect_map_o)
  );

endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
  parameter int NUM_SECTORS = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sect_cmd_i,
  input logic                   susp_cmd_i,
  input logic                   erase_done_i,
  input logic                   win_closed_o,
  input logic [NUM_SECTORS-1:0] sect_map_o,
  input logic                   erase_start_o,
  input logic                   susp_fwd_o,
  input logic                   win_open,
  input logic                   accept,
  input logic                   expire,
  input logic                   abort
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start_o |=> !erase_start_o); // R3

  AST_EXPIRE_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (erase_start_o && win_closed_o)); // R3

  AST_ACCEPT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sect_map_o != '0)); // R4

  AST_EXPIRY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> $stable(sect_map_o)); // R5

  AST_CLOSED_MAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_closed_o && !erase_done_i) |=> ($stable(sect_map_o) && win_closed_o)); // R6

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_closed_o && erase_done_i) |=> (!win_closed_o && sect_map_o == '0)); // R7

  AST_SUSPEND_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (sect_map_o == '0 && !win_closed_o && !win_open)); // R8

  AST_FWD_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    susp_fwd_o |-> (win_closed_o && susp_cmd_i)); // R9

  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && erase_done_i && !susp_cmd_i && !expire) |=> win_open); // R10

endmodule

bind erase_batch_window ebw_checker #(.NUM_SECTORS(NUM_SECTORS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .sect_cmd_i    (sect_cmd_i),
  .susp_cmd_i    (susp_cmd_i),
  .erase_done_i  (erase_done_i),
  .win_closed_o  (win_closed_o),
  .sect_map_o    (sect_map_o),
  .erase_start_o (erase_start_o),
  .susp_fwd_o    (susp_fwd_o),
  .win_open      (win_open_w),
  .accept        (accept_w),
  .expire        (expire_w),
  .abort         (abort_w)
);

// File: tb/erase_batch_window_tb_top.sv
module erase_batch_window_tb_top;

  localparam int NS = 8;
  localparam int W  = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sect_cmd = 1'b0;
  logic [SW-1:0] sect_idx = '0;
  logic          susp_cmd = 1'b0;
  logic          erase_done = 1'b0;
  logic          closed;
  logic [NS-1:0] smap;
  logic          start;
  logic          susp_fwd;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  erase_batch_window #(.NUM_SECTORS(NS), .WINDOW_CYCLES(W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sect_cmd_i   (sect_cmd),
    .sect_idx_i   (sect_idx),
    .susp_cmd_i   (susp_cmd),
    .erase_done_i (erase_done),
    .win_closed_o (closed),
    .sect_map_o   (smap),
    .erase_start_o(start),
    .susp_fwd_o   (susp_fwd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] bitof(input int i);
    return NS'(1) << i;
  endfunction

  // Drives a done pulse at a negedge and checks the cleared state after the edge.
  task automatic finish_erase();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    check(closed == 1'b0, "R7 flag cleared", closed, 0);
    check(smap == '0, "R7 map cleared", smap, 0);
  endtask

  // Runs a schedule where request j is sampled cnt_at[j] edges after the first.
  task automatic run_batch(input int n, input int at0, input int at1, input int at2,
                           input int i0, input int i1, input int i2,
                           input int exp_lat, input logic [NS-1:0] exp_map,
                           input string tag);
    int at[3];
    int ix[3];
    int first_lat;
    int starts;
    at[0] = at0; at[1] = at1; at[2] = at2;
    ix[0] = i0;  ix[1] = i1;  ix[2] = i2;
    first_lat = -1;
    starts = 0;
    for (int c = 0; c <= exp_lat + 4; c++) begin
      if (c > 0) begin
        if (start) begin
          starts++;
          if (first_lat < 0) first_lat = c;
        end
        if (c == 1) begin
          check(smap == bitof(ix[0]), "R2 first bit set", smap, bitof(ix[0]));
          check(closed == 1'b0, "R2 flag low while open", closed, 0);
        end
      end
      sect_cmd = 1'b0;
      for (int j = 0; j < n; j++) begin
        if (c == at[j]) begin
          sect_cmd = 1'b1;
          sect_idx = SW'(ix[j]);
        end
      end
      if (c < exp_lat + 4) @(negedge clk);
    end
    sect_cmd = 1'b0;
    check(first_lat == exp_lat, {tag, " start latency"}, first_lat, exp_lat);
    check(starts == 1, "R3 single start pulse", starts, 1);
    check(closed == 1'b1, {tag, " flag high after expiry"}, closed, 1);
    check(smap == exp_map, {tag, " batch bitmap"}, smap, exp_map);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(closed == 1'b0, "R1 flag at reset", closed, 0);
    check(smap == '0, "R1 map at reset", smap, 0);
    check(start == 1'b0, "R1 start at reset", start, 0);
    check(susp_fwd == 1'b0, "R1 fwd at reset", susp_fwd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep spacing of a second request across the whole window (R4, R5).
    for (int k = 1; k <= W; k++) begin
      int a;
      int b;
      logic [NS-1:0] m;
      a = k % NS;
      b = (k + 3) % NS;
      m = bitof(a) | ((k < W) ? bitof(b) : '0);
      run_batch(2, 0, k, -1, a, b, 0, (k < W) ? (k + W + 1) : (W + 1), m,
                (k < W) ? "R4" : "R5");

      // Requests during the erase are ignored (R6).
      sect_cmd = 1'b1;
      sect_idx = SW'((k + 5) % NS);
      @(negedge clk);
      sect_cmd = 1'b0;
      repeat (W + 2) begin
        @(negedge clk);
        check(start == 1'b0, "R6 no restart while closed", start, 0);
      end
      check(smap == m, "R6 map unchanged", smap, m);

      // Suspend is forwarded during the erase (R9).
      susp_cmd = 1'b1;
      #1;
      check(susp_fwd == 1'b1, "R9 suspend forwarded", susp_fwd, 1);
      @(negedge clk);
      susp_cmd = 1'b0;
      #1;
      check(susp_fwd == 1'b0, "R9 fwd drops with strobe", susp_fwd, 0);
      @(negedge clk);
      finish_erase();
    end

    // Three requests each W-1 apart: all accepted, window restarts each time (R3, R4).
    run_batch(3, 0, W - 1, 2 * (W - 1), 0, 4, 7, 2 * (W - 1) + W + 1,
              bitof(0) | bitof(4) | bitof(7), "R3");
    finish_erase();

    // Suspend with a simultaneous request cancels the batch (R8, R9).
    sect_cmd = 1'b1; sect_idx = 3'd2;
    @(negedge clk);
    sect_cmd = 1'b0;
    repeat (2) @(negedge clk);
    sect_cmd = 1'b1; sect_idx = 3'd5; susp_cmd = 1'b1;
    #1;
    check(susp_fwd == 1'b0, "R9 no forward while open", susp_fwd, 0);
    @(negedge clk);
    sect_cmd = 1'b0; susp_cmd = 1'b0;
    check(smap == '0, "R8 map cleared by suspend", smap, 0);
    begin
      int seen;
      seen = 0;
      repeat (W + 3) begin
        @(negedge clk);
        if (start || closed) seen++;
      end
      check(seen == 0, "R8 nothing launched", seen, 0);
    end

    // Stray done inside an open window is ignored (R10).
    sect_cmd = 1'b1; sect_idx = 3'd1;
    @(negedge clk);
    sect_cmd = 1'b0;
    @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    check(smap == bitof(1), "R10 map kept", smap, bitof(1));
    begin
      int lat;
      lat = 3;
      while (!start && lat < 4 * W) begin
        @(negedge clk);
        lat++;
      end
      check(lat == W + 1, "R10 timing kept", lat, W + 1);
    end
    @(negedge clk);
    finish_erase();

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule